// File: doc/BRIEF.md
# Interrupt Acceptance and Mask Unit

This unit decides, every clock, whether the processor takes an interrupt. It holds the 4-bit interrupt mask level of the status register. It looks at a set of maskable request lines, each of which carries a 4-bit priority and a vector number, and at one non-maskable line. When the processor signals that it can take an exception, the unit picks at most one request. It raises a one-cycle accept pulse, presents the chosen vector number so that the handler address can be fetched, and loads the mask with the level of the request it took.

The non-maskable line works on edges. A rising edge leaves a request pending, and that request is served whatever the mask holds. It counts as level 16, so it beats every maskable request, but the mask can only hold 15 and is loaded with that. Entry to the handler is an immediate jump, so one acceptance produces exactly one vector fetch. The fetch needs no delay-slot handling. A restore input reloads the mask when a handler returns.

The control is a two-state machine. `ST_WATCH` is the normal state, in which requests are examined. Transition *take* (an acceptance) moves to `ST_ENTER`. `ST_ENTER` is a single handler-entry cycle in which nothing is accepted. Transition *resume* always returns to `ST_WATCH` on the next edge.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the mask level reads 4'hF, the accept pulse is low and the state is `ST_WATCH`.
- R2: A maskable request is a candidate only when its priority is strictly greater than the current mask level. A priority equal to the mask is refused.
- R3: When a maskable request is taken, the mask level on the following cycle equals that request's priority.
- R4: Among the candidates, the one with the highest priority wins. Among equal priorities, the one with the lowest vector number wins.
- R5: A rising edge on `nmi_req` makes a non-maskable request pending from the next cycle. That request is taken regardless of the mask: `acc_is_nmi` is 1, `acc_vec` equals parameter `NMI_VEC`, and the mask becomes 4'hF.
- R6: A pending non-maskable request is taken before any maskable request in the same cycle. The maskable request stays pending for a later cycle.
- R7: `acc_pulse` is high only in a cycle where `cpu_ready` is high. While `cpu_ready` is low nothing is taken and the mask is unchanged.
- R8: An acceptance moves the machine to `ST_ENTER` for exactly one cycle, in which nothing is accepted. Two acceptances are therefore never on adjacent cycles.
- R9: A cycle with `restore_en` high loads `restore_level` into the mask on the next edge, and no request is taken in that cycle.
- R10: A request with priority 0 is never taken, even with the mask at 0.
- R11: In every cycle without an acceptance, `acc_vec` is 0 and `acc_is_nmi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pend | input | NUM_SRC | Maskable request lines, one per source |
| req_prio | input | 4*NUM_SRC | Priority of each source, source i in bits [4i+3:4i] |
| req_vec | input | VEC_W*NUM_SRC | Vector number of each source, source i in bits [VEC_W*i+VEC_W-1:VEC_W*i] |
| nmi_req | input | 1 | Non-maskable request, acted on at its rising edge |
| cpu_ready | input | 1 | High when the processor can take an exception this cycle |
| restore_en | input | 1 | Reload the mask from `restore_level` |
| restore_level | input | 4 | Mask value restored on return from a handler |
| acc_pulse | output | 1 | One-cycle acceptance strobe |
| acc_vec | output | VEC_W | Vector number of the accepted request, valid with `acc_pulse` |
| acc_is_nmi | output | 1 | The acceptance in this cycle is the non-maskable request |
| mask_level | output | 4 | Current interrupt mask level |

## Verification
Some properties are checked on every cycle by the assertions. An acceptance never happens without `cpu_ready`. It is never followed by another in the next cycle. A maskable acceptance always raises the mask above its old value, and a non-maskable one leaves the mask at 4'hF. A restore lands in the mask. Outside acceptances the vector and the non-maskable flag are zero. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These are: which of several pending requests wins, including ties broken by vector number; a request at a priority equal to the mask being refused; a priority-0 request never being taken; and a non-maskable edge beating a maskable request that is pending in the same cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int LVL_W = 4;
    localparam logic [LVL_W-1:0] LVL_TOP = 4'hF;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_ENTER = 1'b1
    } acc_state_e;

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic nmi_taken,
    output logic nmi_pend
);

    logic nmi_prev;
    logic nmi_rise;

    assign nmi_rise = nmi_req & ~nmi_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_req;
            nmi_pend <= (nmi_pend & ~nmi_taken) | nmi_rise;
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_accept_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int VEC_W   = 8
) (
    input  logic [NUM_SRC-1:0]       pend,
    input  logic [LVL_W*NUM_SRC-1:0] prio_flat,
    input  logic [VEC_W*NUM_SRC-1:0] vec_flat,
    input  logic [LVL_W-1:0]         mask,
    output logic                     win_valid,
    output logic [LVL_W-1:0]         win_prio,
    output logic [VEC_W-1:0]         win_vec
);

    logic [LVL_W-1:0] prio_a [NUM_SRC];
    logic [VEC_W-1:0] vec_a  [NUM_SRC];
    logic [NUM_SRC-1:0] elig;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign prio_a[g] = prio_flat[LVL_W*g +: LVL_W];
        assign vec_a[g]  = vec_flat[VEC_W*g +: VEC_W];
        assign elig[g]   = pend[g] && (prio_a[g] > mask);
    end

    always_comb begin
        win_valid = 1'b0;
        win_prio  = '0;
        win_vec   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i]) begin
                if (!win_valid || (prio_a[i] > win_prio) ||
                    ((prio_a[i] == win_prio) && (vec_a[i] < win_vec))) begin
                    win_valid = 1'b1;
                    win_prio  = prio_a[i];
                    win_vec   = vec_a[i];
                end
            end
        end
    end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int               NUM_SRC = 4,
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = 8'h0B
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req_pend,
    input  logic [LVL_W*NUM_SRC-1:0] req_prio,
    input  logic [VEC_W*NUM_SRC-1:0] req_vec,
    input  logic                     nmi_req,
    input  logic                     cpu_ready,
    input  logic                     restore_en,
    input  logic [LVL_W-1:0]         restore_level,
    output logic                     acc_pulse,
    output logic [VEC_W-1:0]         acc_vec,
    output logic                     acc_is_nmi,
    output logic [LVL_W-1:0]         mask_level
);

    acc_state_e       state_q, state_d;
    logic             nmi_pend;
    logic             win_valid;
    logic [LVL_W-1:0] win_prio;
    logic [VEC_W-1:0] win_vec;
    logic             take, take_nmi;

    irq_nmi_edge u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_req   (nmi_req),
        .nmi_taken (take_nmi),
        .nmi_pend  (nmi_pend)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
        .pend      (req_pend),
        .prio_flat (req_prio),
        .vec_flat  (req_vec),
        .mask      (mask_level),
        .win_valid (win_valid),
        .win_prio  (win_prio),
        .win_vec   (win_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        take       = 1'b0;
        take_nmi   = 1'b0;
        unique case (state_q)
            ST_WATCH: begin
                if (cpu_ready && !restore_en) begin
                    if (nmi_pend) begin
                        take     = 1'b1;
                        take_nmi = 1'b1;
                    end else if (win_valid) begin
                        take     = 1'b1;
                    end
                end
                if (take) state_d = ST_ENTER;
            end
            ST_ENTER: state_d = ST_WATCH;
        endcase
        acc_pulse  = take;
        acc_is_nmi = take_nmi;
        acc_vec    = take_nmi ? NMI_VEC : (take ? win_vec : '0);
    end

    // Mask field of the status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_level <= LVL_TOP;
        else if (restore_en) mask_level <= restore_level;
        else if (take_nmi)   mask_level <= LVL_TOP;
        else if (take)       mask_level <= win_prio;
    end

    assert_accept_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> cpu_ready);

    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |=> !acc_pulse);

    assert_mask_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && !acc_is_nmi) |=> (mask_level > $past(mask_level)));

    assert_nmi_mask_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && acc_is_nmi) |=> (mask_level == LVL_TOP));

    assert_restore_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (mask_level == $past(restore_level)));

    assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_pulse |-> (acc_vec == '0 && !acc_is_nmi));

    assert_win_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio > mask_level && win_prio != 4'h0));

endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;

    localparam int NS = 4;
    localparam int VW = 8;
    localparam logic [VW-1:0] NMIV = 8'h0B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] pend = '0;
    logic [3:0]    prio [NS];
    logic [VW-1:0] vec  [NS];
    logic [4*NS-1:0]  prio_flat;
    logic [VW*NS-1:0] vec_flat;
    logic nmi_req = 1'b0, cpu_ready = 1'b1, restore_en = 1'b0;
    logic [3:0] restore_level = '0;
    logic acc_pulse, acc_is_nmi;
    logic [VW-1:0] acc_vec;
    logic [3:0] mask_level;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // model state
    int m_mask = 15, m_enter = 0, m_nmi_pend = 0, m_nmi_prev = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            prio_flat[4*i +: 4]  = prio[i];
            vec_flat[VW*i +: VW] = vec[i];
        end
    end

    irq_accept_unit #(.NUM_SRC(NS), .VEC_W(VW), .NMI_VEC(NMIV)) i_irq_accept_unit (
        .clk(clk), .rst_n(rst_n), .req_pend(pend), .req_prio(prio_flat),
        .req_vec(vec_flat), .nmi_req(nmi_req), .cpu_ready(cpu_ready),
        .restore_en(restore_en), .restore_level(restore_level),
        .acc_pulse(acc_pulse), .acc_vec(acc_vec), .acc_is_nmi(acc_is_nmi),
        .mask_level(mask_level)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // one cycle: compare model against ports, then advance the model at the edge
    task automatic tick();
        int e_take, e_nmi, e_vec, best_p, best_v, found, n_mask;
        #1;
        e_take = 0; e_nmi = 0; e_vec = 0; found = 0; best_p = 0; best_v = 0;
        for (int i = 0; i < NS; i++) begin
            if (pend[i] && int'(prio[i]) > m_mask) begin
                if (!found || int'(prio[i]) > best_p ||
                    (int'(prio[i]) == best_p && int'(vec[i]) < best_v)) begin
                    found = 1; best_p = prio[i]; best_v = vec[i];
                end
            end
        end
        if (!m_enter && cpu_ready && !restore_en) begin
            if (m_nmi_pend) begin e_take = 1; e_nmi = 1; e_vec = NMIV; end
            else if (found) begin e_take = 1; e_vec = best_v; end
        end
        chk("acc_pulse", acc_pulse, e_take);
        chk("acc_is_nmi", acc_is_nmi, e_nmi);
        chk("acc_vec", acc_vec, e_vec);
        chk("mask_level", mask_level, m_mask);
        n_mask = restore_en ? int'(restore_level) : (e_nmi ? 15 : (e_take ? best_p : m_mask));
        @(posedge clk);
        m_nmi_pend = (m_nmi_pend && !e_nmi) || (nmi_req && !m_nmi_prev);
        m_nmi_prev = nmi_req;
        m_enter = e_take;
        m_mask = n_mask;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic restore(int lvl);
        restore_level = lvl[3:0]; restore_en = 1'b1;
        tick();
        restore_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin prio[i] = '0; vec[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible while still in reset, then after release
        cur_req = "R1";
        chk("mask_level", mask_level, 15);
        chk("acc_pulse", acc_pulse, 0);
        rst_n = 1'b1;
        run(2);

        // R2: request refused with mask at top
        cur_req = "R2";
        pend = 4'b0001; prio[0] = 4'd9; vec[0] = 8'h20;
        run(3);
        pend = '0;
        // R9: restore reloads mask, blocks acceptance that cycle
        cur_req = "R9";
        pend = 4'b0001;
        restore(0);
        // R3/R8: accepted next, mask becomes 9, one enter cycle
        cur_req = "R3";
        run(1);
        cur_req = "R8";
        run(2);
        pend = '0;

        // R2: equal priority refused, higher taken
        cur_req = "R2";
        restore(5);
        pend = 4'b0010; prio[1] = 4'd5; vec[1] = 8'h21;
        run(3);
        prio[1] = 4'd6;
        run(3);
        pend = '0;

        // R4: highest priority, tie by lowest vector
        cur_req = "R4";
        restore(0);
        prio[0] = 4'd3; vec[0] = 8'h40;
        prio[1] = 4'd7; vec[1] = 8'h30;
        prio[2] = 4'd7; vec[2] = 8'h10;
        prio[3] = 4'd2; vec[3] = 8'h05;
        pend = 4'b1111;
        run(2);
        pend = '0;
        restore(0);
        prio[2] = 4'd7; vec[2] = 8'h50;
        pend = 4'b0111;
        run(2);
        pend = '0;

        // R7: cpu_ready low holds everything
        cur_req = "R7";
        restore(1);
        cpu_ready = 1'b0;
        pend = 4'b0001; prio[0] = 4'd4; vec[0] = 8'h44;
        run(4);
        cpu_ready = 1'b1;
        run(2);
        pend = '0;

        // R5: NMI with mask at top
        cur_req = "R5";
        restore(15);
        nmi_req = 1'b1;
        run(4);
        nmi_req = 1'b0;
        run(1);

        // R6: NMI and maskable together
        cur_req = "R6";
        restore(2);
        pend = 4'b0010; prio[1] = 4'd8; vec[1] = 8'h33;
        cpu_ready = 1'b0;
        nmi_req = 1'b1;
        run(2);
        cpu_ready = 1'b1;
        run(2);
        nmi_req = 1'b0;
        restore(2);
        run(2);
        pend = '0;

        // R10: priority 0 never accepted
        cur_req = "R10";
        restore(0);
        pend = 4'b1000; prio[3] = 4'd0; vec[3] = 8'h01;
        run(4);
        pend = '0;

        // R11: idle outputs stay zero
        cur_req = "R11";
        run(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule